// File: doc/BRIEF.md
# PWM Fault Latch and Recovery Controller

This block sits between a PWM generator and the output pins of one power stage with three outputs (A, B, X). It watches four fault channels. Each channel gives it a raw pin state and a filtered pin state, both taken through a per-channel active-level select. A new filtered fault sets a sticky flag, which can raise a per-channel interrupt request, and sets a per-channel hold latch. Every output forces itself to a programmed safe state while any fault mapped to it is held or its raw input is active. The raw path is combinational, so an output turns off before the filter has accepted the fault, and the generator keeps running.

A held channel is released only on a qualifying PWM boundary strobe, full cycle, half cycle or both, as chosen per channel. There are three recovery modes. Automatic mode releases once the filtered fault has gone away. Manual mode releases once software has cleared the flag. Safe-manual mode needs both conditions at the boundary instant. Software clears flags by writing ones to a clear port, and it programs the per-output fault masks through a load port.

Top module: `pwm_fault_guard`

## Requirements
- R1: While reset is held and after it, every flag and every hold latch is 1 and every mask bit is 1, so each output sits in its fault state and irq equals irq_en.
- R2: A fault channel is active when its pin equals flt_pol (1 = active high). A 0-to-1 change of the active filtered state sets that channel's flag and hold latch at the next clock edge.
- R3: A 1 on flag_clr[i] clears flag i at the next edge, unless a new filtered event on channel i comes in the same cycle, in which case the flag stays set.
- R4: irq[i] equals flag[i] AND irq_en[i] in every cycle.
- R5: A mapped raw fault that is active forces its output to the fault state in the same cycle, whatever the filtered input, flag or latch hold.
- R6: With rcv_auto[i]=1, hold i is cleared at a qualifying boundary when the filtered fault is inactive; flag_clr has no effect on hold i.
- R7: With rcv_auto[i]=0 and rcv_safe[i]=0, hold i is cleared at a qualifying boundary if flag i was already clear before that edge; the filtered pin is not looked at.
- R8: With rcv_auto[i]=0 and rcv_safe[i]=1, hold i is cleared at a qualifying boundary only if flag i is clear and the filtered fault is inactive in that cycle.
- R9: A boundary qualifies for channel i when (full_stb AND rcv_full_en[i]) OR (half_stb AND rcv_half_en[i]); with both enables 0 the hold never clears.
- R10: off_state bits [2o+1:2o] set output o (0=A, 1=B, 2=X): 00 drives 0, 01 drives 1, 1x tristates (pwm_oe=0, pwm_out=0). out_inv[o] inverts driven levels, both the fault state and the normal pwm_in, but not tristate. An output that is not forced gives pwm_in^out_inv with pwm_oe=1.
- R11: When map_we=1, map_d loads the masks at the next edge. Bit o*4+i maps fault i to output o. Output o is forced when any mapped channel has hold set or an active raw input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_raw | input | 4 | Unfiltered fault pins |
| flt_filt | input | 4 | Filtered fault pins |
| flt_pol | input | 4 | Active level per channel (1 = high) |
| rcv_auto | input | 4 | Automatic recovery select |
| rcv_safe | input | 4 | Safe check for manual recovery |
| rcv_full_en | input | 4 | Allow recovery at full-cycle strobe |
| rcv_half_en | input | 4 | Allow recovery at half-cycle strobe |
| full_stb | input | 1 | Full-cycle boundary pulse |
| half_stb | input | 1 | Half-cycle boundary pulse |
| flag_clr | input | 4 | Write-one-to-clear for flags |
| irq_en | input | 4 | Interrupt enables |
| map_we | input | 1 | Mask load strobe |
| map_d | input | 12 | Mask load data |
| off_state | input | 6 | Fault state per output |
| out_inv | input | 3 | Output polarity inversion |
| pwm_in | input | 3 | Generator outputs A, B, X |
| pwm_out | output | 3 | Gated output levels |
| pwm_oe | output | 3 | Output enables |
| irq | output | 4 | Interrupt requests |

## Verification
The risky collisions are a new filtered fault arriving in the same cycle as a software clear of the same flag, and a flag clear arriving in the same cycle as a boundary strobe in manual mode. The bench drives both on purpose. It raises a filtered input while pulsing the clear bit, and it strobes boundaries right after or together with clears. A behavioural model written as per-channel rules is compared against the outputs and interrupt requests on every clock. It expects the event to win, and it expects manual release only at a boundary that comes after the edge that cleared the flag.

// File: rtl/pwm_fault_pkg.sv
package pwm_fault_pkg;

    localparam int NUM_FLT = 4;
    localparam int NUM_OUT = 3;

    typedef enum logic [1:0] {
        FS_LOW  = 2'b00,
        FS_HIGH = 2'b01,
        FS_HIZ0 = 2'b10,
        FS_HIZ1 = 2'b11
    } fstate_e;

    typedef enum logic [1:0] {
        RCV_AUTO   = 2'd0,
        RCV_MANUAL = 2'd1,
        RCV_SAFE   = 2'd2
    } rcv_mode_e;

    typedef struct packed {
        logic level;
        logic en;
    } pin_drive_t;

    function automatic rcv_mode_e mode_of(input logic auto_c, input logic safe_c);
        if (auto_c)      return RCV_AUTO;
        else if (safe_c) return RCV_SAFE;
        else             return RCV_MANUAL;
    endfunction

    function automatic pin_drive_t fault_drive(input logic [1:0] st, input logic inv);
        pin_drive_t d;
        case (fstate_e'(st))
            FS_LOW:  d = '{level: inv,        en: 1'b1};
            FS_HIGH: d = '{level: ~inv,       en: 1'b1};
            default: d = '{level: 1'b0,       en: 1'b0};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/fault_channel.sv
module fault_channel
    import pwm_fault_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic raw_in,
    input  logic filt_in,
    input  logic pol,
    input  logic auto_c,
    input  logic safe_c,
    input  logic full_en,
    input  logic half_en,
    input  logic full_stb,
    input  logic half_stb,
    input  logic clr,
    output logic raw_act,
    output logic flag,
    output logic hold
);
    logic      filt_act, prev_act, rise, bnd, ok;
    rcv_mode_e mode;

    assign raw_act  = ~(raw_in ^ pol);
    assign filt_act = ~(filt_in ^ pol);
    assign rise     = filt_act & ~prev_act;
    assign bnd      = (full_stb & full_en) | (half_stb & half_en);
    assign mode     = mode_of(auto_c, safe_c);

    always_comb begin
        case (mode)
            RCV_AUTO:   ok = ~filt_act;
            RCV_MANUAL: ok = ~flag;
            RCV_SAFE:   ok = ~flag & ~filt_act;
            default:    ok = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag     <= 1'b1;
            hold     <= 1'b1;
            prev_act <= 1'b0;
        end else begin
            prev_act <= filt_act;
            flag     <= rise | (flag & ~clr);
            hold     <= rise | (hold & ~(bnd & ok));
        end
    end

    a_r2_flag_on_event: assert property (@(posedge clk) disable iff (rst)
        rise |=> (flag && hold));

    a_r3_clear_takes_effect: assert property (@(posedge clk) disable iff (rst)
        (clr && !rise) |=> !flag);

    a_r9_release_only_at_boundary: assert property (@(posedge clk) disable iff (rst)
        $fell(hold) |-> $past(bnd));

    a_r8_safe_waits_for_pin: assert property (@(posedge clk) disable iff (rst)
        (hold && mode == RCV_SAFE && filt_act) |=> hold);

    a_r6_auto_ignores_clear: assert property (@(posedge clk) disable iff (rst)
        (hold && auto_c && !bnd) |=> hold);

endmodule

// File: rtl/out_gate.sv
module out_gate
    import pwm_fault_pkg::*;
#(
    parameter int NF = NUM_FLT
) (
    input  logic [NF-1:0] mask,
    input  logic [NF-1:0] live,
    input  logic          pwm_in,
    input  logic [1:0]    st,
    input  logic          inv,
    output logic          out,
    output logic          oe
);
    logic       dis;
    pin_drive_t drv;

    assign dis = |(mask & live);

    always_comb begin
        if (dis) drv = fault_drive(st, inv);
        else     drv = '{level: pwm_in ^ inv, en: 1'b1};
    end

    assign out = drv.level;
    assign oe  = drv.en;

    always_comb begin
        if (dis && st[1]) a_r10_tristate_undriven: assert (!oe && !out);
    end

endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
    import pwm_fault_pkg::*;
#(
    parameter int NF = NUM_FLT,
    parameter int NO = NUM_OUT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NF-1:0]    flt_raw,
    input  logic [NF-1:0]    flt_filt,
    input  logic [NF-1:0]    flt_pol,
    input  logic [NF-1:0]    rcv_auto,
    input  logic [NF-1:0]    rcv_safe,
    input  logic [NF-1:0]    rcv_full_en,
    input  logic [NF-1:0]    rcv_half_en,
    input  logic             full_stb,
    input  logic             half_stb,
    input  logic [NF-1:0]    flag_clr,
    input  logic [NF-1:0]    irq_en,
    input  logic             map_we,
    input  logic [NO*NF-1:0] map_d,
    input  logic [2*NO-1:0]  off_state,
    input  logic [NO-1:0]    out_inv,
    input  logic [NO-1:0]    pwm_in,
    output logic [NO-1:0]    pwm_out,
    output logic [NO-1:0]    pwm_oe,
    output logic [NF-1:0]    irq
);
    localparam int MAPW = NO * NF;

    logic [MAPW-1:0] map_q;
    logic [NF-1:0]   raw_act, flag, hold, live;

    always_ff @(posedge clk) begin
        if (rst)         map_q <= '1;
        else if (map_we) map_q <= map_d;
    end

    for (genvar i = 0; i < NF; i++) begin : g_ch
        fault_channel u_ch (
            .clk      (clk),
            .rst      (rst),
            .raw_in   (flt_raw[i]),
            .filt_in  (flt_filt[i]),
            .pol      (flt_pol[i]),
            .auto_c   (rcv_auto[i]),
            .safe_c   (rcv_safe[i]),
            .full_en  (rcv_full_en[i]),
            .half_en  (rcv_half_en[i]),
            .full_stb (full_stb),
            .half_stb (half_stb),
            .clr      (flag_clr[i]),
            .raw_act  (raw_act[i]),
            .flag     (flag[i]),
            .hold     (hold[i])
        );

        a_r4_request_persists: assert property (@(posedge clk) disable iff (rst)
            ($past(irq[i]) && !$past(flag_clr[i]) && irq_en[i]) |-> irq[i]);
    end

    assign live = hold | raw_act;
    assign irq  = flag & irq_en;

    for (genvar o = 0; o < NO; o++) begin : g_out
        out_gate #(.NF(NF)) u_gate (
            .mask   (map_q[o*NF +: NF]),
            .live   (live),
            .pwm_in (pwm_in[o]),
            .st     (off_state[2*o +: 2]),
            .inv    (out_inv[o]),
            .out    (pwm_out[o]),
            .oe     (pwm_oe[o])
        );

        a_r5_raw_bypass: assert property (@(posedge clk) disable iff (rst)
            (|(map_q[o*NF +: NF] & raw_act) && off_state[2*o+1]) |-> !pwm_oe[o]);
    end

    a_r1_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (&flag && &map_q));

endmodule

// File: tb/tb_pwm_fault_guard.sv
module tb_pwm_fault_guard;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  flt_raw, flt_filt, flt_pol, rcv_auto, rcv_safe, rcv_full_en, rcv_half_en;
    logic        full_stb, half_stb, map_we;
    logic [3:0]  flag_clr, irq_en;
    logic [11:0] map_d;
    logic [5:0]  off_state;
    logic [2:0]  out_inv, pwm_in, pwm_out, pwm_oe;
    logic [3:0]  irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    bit m_flag[4], m_hold[4], m_prev[4];
    bit [11:0] m_map;

    always #10 clk = ~clk;

    pwm_fault_guard dut (
        .clk(clk), .rst(rst), .flt_raw(flt_raw), .flt_filt(flt_filt), .flt_pol(flt_pol),
        .rcv_auto(rcv_auto), .rcv_safe(rcv_safe), .rcv_full_en(rcv_full_en),
        .rcv_half_en(rcv_half_en), .full_stb(full_stb), .half_stb(half_stb),
        .flag_clr(flag_clr), .irq_en(irq_en), .map_we(map_we), .map_d(map_d),
        .off_state(off_state), .out_inv(out_inv), .pwm_in(pwm_in),
        .pwm_out(pwm_out), .pwm_oe(pwm_oe), .irq(irq)
    );

    task automatic model_update();
        if (rst) begin
            for (int i = 0; i < 4; i++) begin
                m_flag[i] = 1; m_hold[i] = 1; m_prev[i] = 0;
            end
            m_map = '1;
        end else begin
            for (int i = 0; i < 4; i++) begin
                bit act, ev, bnd, ok;
                act = (flt_filt[i] == flt_pol[i]);
                ev  = act && !m_prev[i];
                bnd = (full_stb && rcv_full_en[i]) || (half_stb && rcv_half_en[i]);
                if (rcv_auto[i])      ok = !act;
                else if (rcv_safe[i]) ok = !m_flag[i] && !act;
                else                  ok = !m_flag[i];
                m_hold[i] = ev || (m_hold[i] && !(bnd && ok));
                m_flag[i] = ev || (m_flag[i] && !flag_clr[i]);
                m_prev[i] = act;
            end
            if (map_we) m_map = map_d;
        end
    endtask

    task automatic compare(input string tag);
        bit [2:0] eo, ee;
        bit [3:0] ei;
        for (int o = 0; o < 3; o++) begin
            bit forced = 0;
            for (int i = 0; i < 4; i++)
                if (m_map[o*4+i] && (m_hold[i] || flt_raw[i] == flt_pol[i])) forced = 1;
            if (!forced) begin
                eo[o] = pwm_in[o] ^ out_inv[o]; ee[o] = 1;
            end else if (off_state[2*o+1]) begin
                eo[o] = 0; ee[o] = 0;
            end else begin
                eo[o] = off_state[2*o] ^ out_inv[o]; ee[o] = 1;
            end
        end
        for (int i = 0; i < 4; i++) ei[i] = m_flag[i] && irq_en[i];
        checks++;
        if (pwm_out !== eo || pwm_oe !== ee || irq !== ei) begin
            fails++;
            $display("FAIL %s: out=%b oe=%b irq=%b expected out=%b oe=%b irq=%b",
                     tag, pwm_out, pwm_oe, irq, eo, ee, ei);
        end
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        model_update();
        #2;
        compare(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        checks++; fails++;
        $display("FAIL watchdog (all requirements): actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst = 1; flt_raw = 0; flt_filt = 0; flt_pol = 4'b1111;
        rcv_auto = 0; rcv_safe = 0; rcv_full_en = 0; rcv_half_en = 0;
        full_stb = 0; half_stb = 0; flag_clr = 0; irq_en = 4'b1111;
        map_we = 0; map_d = 0; off_state = 0; out_inv = 0; pwm_in = 3'b111;
        repeat (3) tick("R1 reset");
        rst = 0;
        tick("R1 after reset");
        tick("R1 after reset");

        // masks: A<-f0, B<-f1, X<-f2,f3 ; A drives 0, B drives 1, X tristate
        map_d = {4'b1100, 4'b0010, 4'b0001}; map_we = 1; tick("R11 mask load");
        map_we = 0;
        off_state = {2'b10, 2'b01, 2'b00};
        rcv_auto = 4'b0001; rcv_safe = 4'b0100;
        rcv_full_en = 4'b0101; rcv_half_en = 4'b0010;
        flag_clr = 4'b1111; tick("R3 clear all");
        flag_clr = 0; tick("R4 irq low");

        full_stb = 1; tick("R6 R8 full boundary release");
        full_stb = 0; tick("R9 half-only channel kept");
        half_stb = 1; tick("R7 R9 half boundary release");
        half_stb = 0;
        full_stb = 1; half_stb = 1; tick("R9 neither enable");
        full_stb = 0; half_stb = 0;
        map_d = {4'b0100, 4'b0010, 4'b0001}; map_we = 1; tick("R11 remap X");
        map_we = 0; tick("R10 normal pass");

        flt_raw[0] = 1; #1 compare("R5 raw bypass");
        tick("R5 raw bypass held");
        flt_raw[0] = 0; #1 compare("R5 raw released");
        tick("R5 raw released");

        flt_raw[0] = 1; flt_filt[0] = 1; tick("R2 filtered event");
        tick("R4 irq set");
        flag_clr[0] = 1; tick("R6 clear ignored for hold");
        flag_clr[0] = 0; flt_raw[0] = 0;
        full_stb = 1; tick("R6 pin still active");
        full_stb = 0; flt_filt[0] = 0; tick("R6 pin gone");
        full_stb = 1; tick("R6 release");
        full_stb = 0;

        flt_filt[1] = 1; flag_clr[1] = 1; tick("R3 event beats clear");
        flag_clr[1] = 0; tick("R3 flag kept");
        half_stb = 1; tick("R7 flag still set");
        half_stb = 0; flag_clr[1] = 1; half_stb = 1; tick("R7 clear with boundary");
        flag_clr[1] = 0; tick("R7 pin active ignored");
        half_stb = 0; tick("R7 released");

        flt_filt[2] = 1; tick("R2 safe channel event");
        flt_filt[2] = 0; flt_filt[2] = 1; flag_clr[2] = 1; tick("R3 clear");
        flag_clr[2] = 0; full_stb = 1; tick("R8 pin active blocks");
        full_stb = 0; flt_filt[2] = 0; tick("R8 pin gone");
        full_stb = 1; tick("R8 release");
        full_stb = 0;

        out_inv = 3'b111; pwm_in = 3'b010; tick("R10 inverted normal");
        flt_raw[1] = 1; #1 compare("R10 inverted drive-1 state");
        flt_raw[1] = 0; flt_pol[3] = 0; tick("R2 low-active channel");
        tick("R4 low-active irq");

        for (int n = 0; n < 4000; n++) begin
            flt_raw = 4'($urandom); flt_filt = 4'($urandom);
            if (n % 64 == 0) flt_pol = 4'($urandom);
            rcv_auto = 4'($urandom); rcv_safe = 4'($urandom);
            rcv_full_en = 4'($urandom); rcv_half_en = 4'($urandom);
            full_stb = ($urandom % 6 == 0); half_stb = ($urandom % 6 == 0);
            flag_clr = 4'($urandom) & 4'($urandom); irq_en = 4'($urandom);
            map_we = ($urandom % 20 == 0); map_d = 12'($urandom);
            off_state = 6'($urandom); out_inv = 3'($urandom); pwm_in = 3'($urandom);
            rst = ($urandom % 500 == 0);
            tick("R2 R3 R6 R7 R8 R9 R10 R11 mixed");
        end
        finish_run();
    end
endmodule